// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This unit performs add, subtract and absolute-value arithmetic on one 32-bit word at a time. The word can be read in three ways: as a single signed 32-bit value, as two signed 16-bit lanes, or as four unsigned 8-bit lanes. Each operation can either wrap or clamp its result at the lane's range. Carries never cross lane boundaries. Signed 16-bit and Q15 fractional add and subtract give identical bits, so one signed-halfword path serves both.

The unit can also sum the four bytes of one operand into a zero-extended word. Two 32-bit adds can be chained into a 64-bit add. The first add records its carry-out in a carry flag, and a second add uses that flag as its carry-in.

The operands and a 4-bit operation code are presented together with an input strobe. The result appears one clock later, with a matching output strobe. A per-operation overflow bit accompanies each result. A sticky overflow bit collects overflows until it is cleared explicitly.

Top module: `simd_sat_alu`

## Requirements
- R1: Op 0 (`a+b`) and op 1 (`a-b`) on signed 32-bit values clamp to 0x7FFFFFFF or 0x80000000 when the true result is out of range, and they raise the overflow bit when they clamp.
- R2: Op 2 returns the absolute value of signed `a`. For input 0x80000000 it returns 0x7FFFFFFF and raises overflow, so its result bit 31 is always 0.
- R3: Ops 3 (add) and 5 (subtract) work on bits [15:0] and [31:16] as separate signed halves, and each half wraps modulo 2^16. The overflow bit is raised if either half overflows, and no carry or borrow passes between the halves.
- R4: Ops 4 (add) and 6 (subtract) work on the same halves as R3, but each half clamps to 0x7FFF or 0x8000. Overflow is raised if either half clamps.
- R5: Op 7 returns the absolute value of each signed half. A half of 0x8000 becomes 0x7FFF and raises overflow.
- R6: Ops 8 (add) and 10 (subtract) work on four unsigned bytes at bit positions 8k+7..8k. Each byte wraps modulo 256 without carry between bytes, and overflow is raised on any byte carry or borrow.
- R7: Ops 9 (add) and 11 (subtract) work on the same bytes as R6, but each byte clamps to 255 on a carry and to 0 on a borrow. Overflow is raised if any byte clamps.
- R8: Op 12 returns the sum of the four unsigned bytes of `a`, zero-extended to 32 bits, and never raises overflow.
- R9: Op 13 returns `a+b` modulo 2^32 and loads the carry flag with the unsigned carry-out. Op 14 returns `a+b+carry` modulo 2^32 and leaves the carry flag unchanged. Op 14 raises overflow on signed overflow. The carry flag changes only on op 13.
- R10: The overflow output is registered with the result. The sticky bit becomes `(sticky & ~clear) | (strobe & overflow)`, so an overflow in the same cycle as a clear leaves it set.
- R11: The output strobe follows the input strobe by one cycle. The result and overflow outputs hold while no strobe arrives. Op 15 returns 0 with no overflow.
- R12: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sticky_clr | input | 1 | Clears the sticky overflow bit |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Registered result |
| lane_ovf | output | 1 | Overflow of the last operation |
| sticky_ovf | output | 1 | Accumulated overflow |
| carry_flag | output | 1 | Stored carry for chained adds |

## Verification
The block holds only three pieces of state: the carry flag, the sticky bit and the output registers. A wrong carry shows up on the `carry_flag` port in the cycle after the op 13 that loaded it. It also shows up in the result of the next op 14, which adds the flag as a carry-in. A wrong sticky bit appears on its port one cycle after the strobe or clear that should have changed it. A wrong lane boundary or clamp shows in the very next result, so the bench compares every output against a behavioural model on every clock.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_W   = 4'd0,
    OP_SUB_W   = 4'd1,
    OP_ABS_W   = 4'd2,
    OP_ADD_PH  = 4'd3,
    OP_ADDS_PH = 4'd4,
    OP_SUB_PH  = 4'd5,
    OP_SUBS_PH = 4'd6,
    OP_ABS_PH  = 4'd7,
    OP_ADD_QB  = 4'd8,
    OP_ADDS_QB = 4'd9,
    OP_SUB_QB  = 4'd10,
    OP_SUBS_QB = 4'd11,
    OP_SUM_QB  = 4'd12,
    OP_ADD_CG  = 4'd13,
    OP_ADD_CU  = 4'd14,
    OP_NOP     = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic sub;
    logic absop;
    logic sat;
  } lane_ctl_t;

endpackage

// File: rtl/simd_rst_sync.sv
module simd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W      = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         absop,
  input  logic         sat,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         ovf
);
  logic [W-1:0] x, y, sat_val;
  logic [W:0]   xe, ye, sum;
  logic         neg, of;

  always_comb begin
    x   = absop ? '0 : a;
    y   = absop ? a : b;
    neg = sub | (absop & SIGNED & a[W-1]);
    if (SIGNED) begin
      xe = {x[W-1], x};
      ye = {y[W-1], y};
    end else begin
      xe = {1'b0, x};
      ye = {1'b0, y};
    end
    if (neg) begin
      sum = xe - ye;
    end else begin
      sum = xe + ye + {{W{1'b0}}, cin};
    end
    if (SIGNED) begin
      of      = sum[W] ^ sum[W-1];
      sat_val = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      of      = sum[W];
      sat_val = neg ? {W{1'b0}} : {W{1'b1}};
    end
    res = (of && sat) ? sat_val : sum[W-1:0];
    ovf = of;
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter bit SIGNED = 1'b0,
  localparam int TOT_W = LANE_W * LANES
) (
  input  logic [TOT_W-1:0] a,
  input  logic [TOT_W-1:0] b,
  input  simd_alu_pkg::lane_ctl_t ctl,
  input  logic             cin,
  output logic [TOT_W-1:0] res,
  output logic             ovf
);
  logic [LANES-1:0] lane_of;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_cin;
    if (g == 0) begin : g_first
      assign lane_cin = cin;
    end else begin : g_rest
      assign lane_cin = 1'b0;
    end
    simd_lane #(.W(LANE_W), .SIGNED(SIGNED)) u_lane (
      .a     (a[g*LANE_W +: LANE_W]),
      .b     (b[g*LANE_W +: LANE_W]),
      .sub   (ctl.sub),
      .absop (ctl.absop),
      .sat   (ctl.sat),
      .cin   (lane_cin),
      .res   (res[g*LANE_W +: LANE_W]),
      .ovf   (lane_of[g])
    );
  end

  assign ovf = |lane_of;
endmodule

// File: rtl/simd_byte_sum.sv
module simd_byte_sum #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int TOT_W = LANE_W * LANES,
  localparam int SUM_W = LANE_W + $clog2(LANES)
) (
  input  logic [TOT_W-1:0] a,
  output logic [TOT_W-1:0] total
);
  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + {{(SUM_W-LANE_W){1'b0}}, a[i*LANE_W +: LANE_W]};
    end
    total = {{(TOT_W-SUM_W){1'b0}}, acc};
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int DW = 32,
  localparam int PH_W = DW / 2,
  localparam int QB_W = DW / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          sticky_clr,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          lane_ovf,
  output logic          sticky_ovf,
  output logic          carry_flag
);
  import simd_alu_pkg::*;

  alu_op_e   op_e;
  lane_ctl_t w_ctl, ph_ctl, qb_ctl;
  logic      w_cin, rst_n_i;
  logic [DW-1:0] w_res, ph_res, qb_res, sum_res;
  logic          w_of, ph_of, qb_of;
  logic [DW:0]   ucarry;

  logic [DW-1:0] result_d, result_q;
  logic          ovf_d, ovf_q, sticky_d, sticky_q, carry_d, carry_q, vld_q;

  assign op_e = alu_op_e'(op);

  simd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  always_comb begin
    w_ctl.sub    = (op_e == OP_SUB_W);
    w_ctl.absop  = (op_e == OP_ABS_W);
    w_ctl.sat    = (op_e == OP_ADD_W) || (op_e == OP_SUB_W) || (op_e == OP_ABS_W);
    w_cin        = (op_e == OP_ADD_CU) ? carry_q : 1'b0;
    ph_ctl.sub   = (op_e == OP_SUB_PH) || (op_e == OP_SUBS_PH);
    ph_ctl.absop = (op_e == OP_ABS_PH);
    ph_ctl.sat   = (op_e == OP_ADDS_PH) || (op_e == OP_SUBS_PH) || (op_e == OP_ABS_PH);
    qb_ctl.sub   = (op_e == OP_SUB_QB) || (op_e == OP_SUBS_QB);
    qb_ctl.absop = 1'b0;
    qb_ctl.sat   = (op_e == OP_ADDS_QB) || (op_e == OP_SUBS_QB);
  end

  simd_lane_array #(.LANE_W(DW), .LANES(1), .SIGNED(1'b1)) u_word (
    .a(opnd_a), .b(opnd_b), .ctl(w_ctl), .cin(w_cin), .res(w_res), .ovf(w_of)
  );

  simd_lane_array #(.LANE_W(PH_W), .LANES(2), .SIGNED(1'b1)) u_half (
    .a(opnd_a), .b(opnd_b), .ctl(ph_ctl), .cin(1'b0), .res(ph_res), .ovf(ph_of)
  );

  simd_lane_array #(.LANE_W(QB_W), .LANES(4), .SIGNED(1'b0)) u_byte (
    .a(opnd_a), .b(opnd_b), .ctl(qb_ctl), .cin(1'b0), .res(qb_res), .ovf(qb_of)
  );

  simd_byte_sum #(.LANE_W(QB_W), .LANES(4)) u_sum (.a(opnd_a), .total(sum_res));

  assign ucarry = {1'b0, opnd_a} + {1'b0, opnd_b};

  // next-state logic
  always_comb begin
    result_d = result_q;
    ovf_d    = ovf_q;
    carry_d  = carry_q;
    if (in_valid) begin
      unique case (op_e)
        OP_ADD_W, OP_SUB_W, OP_ABS_W, OP_ADD_CU: begin
          result_d = w_res;
          ovf_d    = w_of;
        end
        OP_ADD_PH, OP_ADDS_PH, OP_SUB_PH, OP_SUBS_PH, OP_ABS_PH: begin
          result_d = ph_res;
          ovf_d    = ph_of;
        end
        OP_ADD_QB, OP_ADDS_QB, OP_SUB_QB, OP_SUBS_QB: begin
          result_d = qb_res;
          ovf_d    = qb_of;
        end
        OP_SUM_QB: begin
          result_d = sum_res;
          ovf_d    = 1'b0;
        end
        OP_ADD_CG: begin
          result_d = ucarry[DW-1:0];
          ovf_d    = 1'b0;
          carry_d  = ucarry[DW];
        end
        default: begin
          result_d = '0;
          ovf_d    = 1'b0;
        end
      endcase
    end
    sticky_d = (sticky_q & ~sticky_clr) | (in_valid & ovf_d);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
      sticky_q <= 1'b0;
      carry_q  <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      vld_q    <= in_valid;
      sticky_q <= sticky_d;
      if (in_valid) begin
        result_q <= result_d;
        ovf_q    <= ovf_d;
        carry_q  <= carry_d;
      end
    end
  end

  assign out_valid  = vld_q;
  assign result     = result_q;
  assign lane_ovf   = ovf_q;
  assign sticky_ovf = sticky_q;
  assign carry_flag = carry_q;
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic          sticky_clr,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          lane_ovf,
  input logic          sticky_ovf,
  input logic          carry_flag
);
  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(lane_ovf)));

  p_abs_w_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2) |=> !result[DW-1]);

  p_abs_ph_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7) |=> (!result[DW-1] && !result[DW/2-1]));

  p_sum_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd12) |=> (result[DW-1:10] == '0 && !lane_ovf));

  p_carry_only_gen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && op == 4'd13) |=> $stable(carry_flag));

  p_sticky_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !in_valid) |=> !sticky_ovf);

  p_sticky_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lane_ovf) |-> sticky_ovf);
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sticky_clr(sticky_clr),
  .out_valid(out_valid), .result(result), .lane_ovf(lane_ovf),
  .sticky_ovf(sticky_ovf), .carry_flag(carry_flag)
);

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        sticky_clr = 1'b0;
  logic        out_valid, lane_ovf, sticky_ovf, carry_flag;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  logic [31:0] e_res = '0;
  bit e_valid = 0, e_ovf = 0, e_sticky = 0, e_carry = 0;
  string e_tag = "R12";
  bit in_reset = 1;

  always #2.5 clk = ~clk;

  simd_sat_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sticky_clr(sticky_clr),
    .out_valid(out_valid), .result(result), .lane_ovf(lane_ovf),
    .sticky_ovf(sticky_ovf), .carry_flag(carry_flag)
  );

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic string tag_of(int o);
    case (o)
      0, 1:   return "R1";
      2:      return "R2";
      3, 5:   return "R3";
      4, 6:   return "R4";
      7:      return "R5";
      8, 10:  return "R6";
      9, 11:  return "R7";
      12:     return "R8";
      13, 14: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic void model(input int o, input logic [31:0] a, input logic [31:0] b,
                                input bit cy, output logic [31:0] r, output bit of, output bit ncy);
    longint s;
    int ai, bi, v;
    r = '0; of = 0; ncy = cy;
    case (o)
      0, 1, 2: begin
        if (o == 0)      s = longint'($signed(a)) + longint'($signed(b));
        else if (o == 1) s = longint'($signed(a)) - longint'($signed(b));
        else             s = a[31] ? -longint'($signed(a)) : longint'($signed(a));
        if (s > 64'sd2147483647)       begin r = 32'h7FFFFFFF; of = 1; end
        else if (s < -64'sd2147483648) begin r = 32'h80000000; of = 1; end
        else r = s[31:0];
      end
      3, 4, 5, 6, 7: begin
        for (int l = 0; l < 2; l++) begin
          ai = int'($signed(a[16*l +: 16]));
          bi = int'($signed(b[16*l +: 16]));
          if (o == 3 || o == 4) v = ai + bi;
          else if (o == 7)      v = (ai < 0) ? -ai : ai;
          else                  v = ai - bi;
          if (v > 32767 || v < -32768) begin
            of = 1;
            if (o == 4 || o == 6 || o == 7) v = (v > 0) ? 32767 : -32768;
          end
          r[16*l +: 16] = v[15:0];
        end
      end
      8, 9, 10, 11: begin
        for (int l = 0; l < 4; l++) begin
          ai = int'(a[8*l +: 8]);
          bi = int'(b[8*l +: 8]);
          v = (o == 8 || o == 9) ? ai + bi : ai - bi;
          if (v > 255 || v < 0) begin
            of = 1;
            if (o == 9 || o == 11) v = (v > 255) ? 255 : 0;
          end
          r[8*l +: 8] = v[7:0];
        end
      end
      12: begin
        v = 0;
        for (int l = 0; l < 4; l++) v += int'(a[8*l +: 8]);
        r = v;
      end
      13: begin
        s = longint'({32'h0, a}) + longint'({32'h0, b});
        r = s[31:0];
        ncy = s[32];
      end
      14: begin
        s = longint'($signed(a)) + longint'($signed(b)) + longint'(cy);
        of = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        r = s[31:0];
      end
      default: begin r = '0; of = 0; end
    endcase
  endfunction

  task automatic cmp1(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string t;
    t = in_reset ? "R12" : "R11";
    cmp1("out_valid", t, {31'b0, out_valid}, {31'b0, e_valid});
    cmp1("result", in_reset ? "R12" : e_tag, result, e_res);
    cmp1("lane_ovf", in_reset ? "R12" : "R10", {31'b0, lane_ovf}, {31'b0, e_ovf});
    cmp1("sticky_ovf", in_reset ? "R12" : "R10", {31'b0, sticky_ovf}, {31'b0, e_sticky});
    cmp1("carry_flag", in_reset ? "R12" : "R9", {31'b0, carry_flag}, {31'b0, e_carry});
  endtask

  // one clock: check the outputs of the previous edge, drive the next inputs
  task automatic step(bit v, int o, logic [31:0] a, logic [31:0] b, bit clr);
    logic [31:0] r;
    bit of, ncy;
    @(negedge clk);
    check_all();
    in_valid = v; op = 4'(o); opnd_a = a; opnd_b = b; sticky_clr = clr;
    e_valid = v;
    if (v) begin
      model(o, a, b, e_carry, r, of, ncy);
      e_res = r; e_ovf = of; e_carry = ncy; e_tag = tag_of(o);
    end
    e_sticky = (e_sticky & ~clr) | (v & of & v);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 32'h7FFF_7FFF;
      1: return 32'h8000_8000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    // R12: reset held
    for (int i = 0; i < 3; i++) step(0, 0, '0, '0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, '0, '0, 0);
    in_reset = 0;
    // R1 word saturation
    step(1, 0, 32'h7FFFFFFF, 32'h1, 0);
    step(1, 1, 32'h80000000, 32'h1, 0);
    step(1, 0, 32'h12345678, 32'h11111111, 0);
    // R10 clear alone then clear with simultaneous overflow
    step(0, 0, '0, '0, 1);
    step(1, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1);
    step(0, 0, '0, '0, 1);
    // R2
    step(1, 2, 32'h80000000, 32'h0, 0);
    step(1, 2, 32'hFFFFFFFB, 32'h0, 0);
    // R3 wrapping halves, low half overflow must not touch high half
    step(1, 3, 32'h0001_7FFF, 32'h0000_0001, 0);
    step(1, 5, 32'h0000_8000, 32'h0000_0001, 0);
    // R4
    step(1, 4, 32'h7FFF_8000, 32'h0001_FFFF, 0);
    step(1, 6, 32'h8000_7FFF, 32'h0001_FFFF, 0);
    // R5
    step(1, 7, 32'h8000_FFFE, 32'h0, 0);
    // R6 bytes wrap independently
    step(1, 8, 32'h00FF_01FF, 32'h0001_0101, 0);
    step(1, 10, 32'h0000_0100, 32'h0001_0001, 0);
    // R7
    step(1, 9, 32'hF0FF_1080, 32'h2001_1080, 0);
    step(1, 11, 32'h0510_2000, 32'h0620_1001, 0);
    // R8
    step(1, 12, 32'hFFFF_FFFF, 32'h1234, 0);
    step(1, 12, 32'h0102_0304, 32'h0, 0);
    // R9 64-bit chain: 0x00000001_FFFFFFFF + 0x00000002_00000001
    step(1, 13, 32'hFFFFFFFF, 32'h00000001, 0);
    step(1, 14, 32'h00000001, 32'h00000002, 0);
    step(1, 14, 32'h7FFFFFFF, 32'h00000000, 0);
    step(1, 13, 32'h00000001, 32'h00000001, 0);
    step(1, 14, 32'h7FFFFFFF, 32'h00000000, 0);
    // R11 reserved op and idle hold
    step(1, 15, 32'hDEADBEEF, 32'h1, 0);
    step(0, 3, 32'h7FFF7FFF, 32'h7FFF7FFF, 0);
    step(0, 13, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    // randomized mix
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), pick_val(), pick_val(),
           $urandom_range(0, 9) == 0);
    end
    step(0, 0, '0, '0, 0);
    step(0, 0, '0, '0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule